// File: doc/BRIEF.md
# Dual-Rounding Signed Divider

This block divides a dividend by a divisor over several clock cycles and returns a quotient and a remainder. The two operands can have different widths. A flag for each operand chooses whether it is read as two's complement or as unsigned. A mode bit, sampled together with the operands, chooses how the quotient is rounded. Truncating mode rounds toward zero, and the remainder then carries the dividend's sign. Flooring mode rounds toward negative infinity, and the remainder then carries the divisor's sign.

The block widens both operands to a common working width and takes their magnitudes. It forms one quotient bit per clock with a restoring shift-subtract loop. A final stage then restores the signs and, for flooring mode, moves a truncated result one step down. A caller pulses `start` while `busy` is low. It then waits for the one-cycle `done` pulse and reads the results, which stay in place until the next `done`.

The working width is WORK_W = max(A_W, B_W, Y_W) + 1, which is 17 with the default parameters.

Top module: `div_dual_round`

## Requirements
- R1: An operand whose signedness flag is 1 is sign-extended to the working width, and one whose flag is 0 is zero-extended. So dividend 16'hFFF6 gives quotient 21842 over divisor 3 when unsigned, and quotient -3 when signed.
- R2: With `floor_mode` = 0, the quotient is the exact quotient rounded toward zero, and a nonzero remainder has the sign of the dividend (-10/3 gives -3 r -1; 10/-3 gives -3 r 1).
- R3: With `floor_mode` = 1, the quotient is rounded toward negative infinity, and a nonzero remainder has the sign of the divisor (-10/3 gives -4 r 2; 10/-3 gives -4 r -2).
- R4: When the division is exact, or when both operands have the same sign, both modes give the same result (-10/-3 gives 3 r -1, and 10/3 gives 3 r 1).
- R5: A `start` seen while `busy` is 0 raises `busy` in the next cycle for WORK_W+1 cycles. `done` is then high for exactly one cycle, with `busy` low.
- R6: `start` is ignored while `busy` is 1. The running operation finishes with its own operands.
- R7: A zero divisor completes with the same latency. It returns an all-ones quotient, a remainder equal to the extended dividend, and `div_zero` = 1. Otherwise `div_zero` = 0.
- R8: The results are the low Y_W bits of the exact working-width results. The most negative 16-bit dividend divided by signed -1 gives quotient 16'h8000.
- R9: During and just after reset, `busy`, `done`, `div_zero`, `quotient` and `remainder` are all 0.
- R10: `quotient`, `remainder` and `div_zero` change only in a cycle where `done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only while idle) |
| floor_mode | input | 1 | 0 = truncating, 1 = flooring |
| dvd_in | input | A_W | Dividend |
| dvd_signed | input | 1 | Dividend is two's complement |
| dsr_in | input | B_W | Divisor |
| dsr_signed | input | 1 | Divisor is two's complement |
| quotient | output | Y_W | Quotient, low Y_W bits |
| remainder | output | Y_W | Remainder, low Y_W bits |
| div_zero | output | 1 | Last operation had a zero divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the results update |

## Verification
The assertions assume that `start` is only useful while the block is idle. They also assume that the operands and mode only matter in the cycle that `start` is accepted, so their values at other times are ignored. The stimulus keeps `start` as a one-cycle pulse placed on a falling edge. The one exception is a deliberate pulse in the middle of an operation, which checks that the request is dropped. The operands come from random values, the signed corner cases and a zero divisor, and every width and flag combination is legal. This means no input pattern lies outside what the properties assume.

// File: rtl/div_dual_round_pkg.sv
package div_dual_round_pkg;

   typedef enum logic [1:0] {
      DV_IDLE = 2'd0,
      DV_ITER = 2'd1,
      DV_FIX  = 2'd2
   } dv_state_e;

   function automatic int dv_max3(input int x, input int y, input int z);
      int m;
      m = (x > y) ? x : y;
      return (m > z) ? m : z;
   endfunction

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 17
) (
   input  logic [IN_W-1:0]  raw,
   input  logic             is_signed,
   output logic [OUT_W-1:0] ext,
   output logic [OUT_W-1:0] mag,
   output logic             neg
);
   localparam int PAD_W = OUT_W - IN_W;

   logic fill;

   generate
      if (PAD_W < 1) begin : g_bad_width
         $error("div_operand_prep: OUT_W must exceed IN_W");
      end
   endgenerate

   always_comb begin
      fill = is_signed & raw[IN_W-1];
      ext  = {{PAD_W{fill}}, raw};
      neg  = ext[OUT_W-1];
      mag  = neg ? (~ext + 1'b1) : ext;
   end

endmodule

// File: rtl/div_restoring_core.sv
module div_restoring_core #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] dvd_mag,
   input  logic [W-1:0] dsr_mag,
   output logic [W-1:0] q_mag,
   output logic [W-1:0] r_mag
);
   logic [W-1:0] acc_q;
   logic [W-1:0] shf_q;
   logic [W-1:0] dsr_q;
   logic [W-1:0] shifted;
   logic [W:0]   trial;
   logic         fits;

   always_comb begin
      shifted = {acc_q[W-2:0], shf_q[W-1]};
      trial   = {1'b0, shifted} - {1'b0, dsr_q};
      fits    = ~trial[W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         shf_q <= '0;
         dsr_q <= '0;
      end else if (load) begin
         acc_q <= '0;
         shf_q <= dvd_mag;
         dsr_q <= dsr_mag;
      end else if (step) begin
         acc_q <= fits ? trial[W-1:0] : shifted;
         shf_q <= {shf_q[W-2:0], fits};
      end
   end

   assign q_mag = shf_q;
   assign r_mag = acc_q;

endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
   parameter int W = 17
) (
   input  logic [W-1:0] q_mag,
   input  logic [W-1:0] r_mag,
   input  logic         dvd_neg,
   input  logic         dsr_neg,
   input  logic [W-1:0] dvd_ext,
   input  logic [W-1:0] dsr_ext,
   input  logic         floor_sel,
   input  logic         zero_dsr,
   output logic [W-1:0] q_res,
   output logic [W-1:0] r_res
);
   logic [W-1:0] q_trunc;
   logic [W-1:0] r_trunc;
   logic         signs_differ;
   logic         bump;

   always_comb begin
      signs_differ = dvd_neg ^ dsr_neg;
      q_trunc      = signs_differ ? (~q_mag + 1'b1) : q_mag;
      r_trunc      = dvd_neg ? (~r_mag + 1'b1) : r_mag;
      bump         = floor_sel & signs_differ & (|r_mag);
      if (zero_dsr) begin
         q_res = '1;
         r_res = dvd_ext;
      end else if (bump) begin
         q_res = q_trunc - 1'b1;
         r_res = r_trunc + dsr_ext;
      end else begin
         q_res = q_trunc;
         r_res = r_trunc;
      end
   end

endmodule

// File: rtl/div_dual_round.sv
module div_dual_round
   import div_dual_round_pkg::*;
#(
   parameter int A_W = 16,
   parameter int B_W = 12,
   parameter int Y_W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           floor_mode,
   input  logic [A_W-1:0] dvd_in,
   input  logic           dvd_signed,
   input  logic [B_W-1:0] dsr_in,
   input  logic           dsr_signed,
   output logic [Y_W-1:0] quotient,
   output logic [Y_W-1:0] remainder,
   output logic           div_zero,
   output logic           busy,
   output logic           done
);
   localparam int WORK_W = dv_max3(A_W, B_W, Y_W) + 1;
   localparam int CNT_W  = $clog2(WORK_W + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WORK_W);

   generate
      if (A_W < 2 || B_W < 2 || Y_W < 2) begin : g_bad_params
         $error("div_dual_round: operand and result widths must be at least 2");
      end
   endgenerate

   dv_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORK_W-1:0] a_ext, a_mag, b_ext, b_mag;
   logic              a_neg, b_neg;
   logic [WORK_W-1:0] a_ext_q, b_ext_q;
   logic              a_neg_q, b_neg_q, floor_q, zero_q;
   logic [WORK_W-1:0] q_mag, r_mag, q_res, r_res;
   logic              accept;
   logic              stepping;

   div_operand_prep #(.IN_W(A_W), .OUT_W(WORK_W)) u_prep_dvd (
      .raw(dvd_in), .is_signed(dvd_signed), .ext(a_ext), .mag(a_mag), .neg(a_neg)
   );

   div_operand_prep #(.IN_W(B_W), .OUT_W(WORK_W)) u_prep_dsr (
      .raw(dsr_in), .is_signed(dsr_signed), .ext(b_ext), .mag(b_mag), .neg(b_neg)
   );

   assign accept   = start && (state_q == DV_IDLE);
   assign stepping = (state_q == DV_ITER);

   div_restoring_core #(.W(WORK_W)) u_core (
      .clk(clk), .rst_n(rst_n), .load(accept), .step(stepping),
      .dvd_mag(a_mag), .dsr_mag(b_mag), .q_mag(q_mag), .r_mag(r_mag)
   );

   div_sign_fix #(.W(WORK_W)) u_fix (
      .q_mag(q_mag), .r_mag(r_mag), .dvd_neg(a_neg_q), .dsr_neg(b_neg_q),
      .dvd_ext(a_ext_q), .dsr_ext(b_ext_q), .floor_sel(floor_q),
      .zero_dsr(zero_q), .q_res(q_res), .r_res(r_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DV_IDLE;
         cnt_q   <= '0;
         a_ext_q <= '0;
         b_ext_q <= '0;
         a_neg_q <= 1'b0;
         b_neg_q <= 1'b0;
         floor_q <= 1'b0;
         zero_q  <= 1'b0;
      end else begin
         case (state_q)
            DV_IDLE: begin
               if (start) begin
                  state_q <= DV_ITER;
                  cnt_q   <= CNT_LOAD;
                  a_ext_q <= a_ext;
                  b_ext_q <= b_ext;
                  a_neg_q <= a_neg;
                  b_neg_q <= b_neg;
                  floor_q <= floor_mode;
                  zero_q  <= ~|b_mag;
               end
            end
            DV_ITER: begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CNT_W'(1)) state_q <= DV_FIX;
            end
            DV_FIX:  state_q <= DV_IDLE;
            default: state_q <= DV_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quotient  <= '0;
         remainder <= '0;
         div_zero  <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= (state_q == DV_FIX);
         if (state_q == DV_FIX) begin
            quotient  <= q_res[Y_W-1:0];
            remainder <= r_res[Y_W-1:0];
            div_zero  <= zero_q;
         end
      end
   end

   assign busy = (state_q != DV_IDLE);

endmodule

// File: rtl/div_dual_round_chk.sv
module div_dual_round_chk #(
   parameter int A_W = 16,
   parameter int B_W = 12,
   parameter int Y_W = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [Y_W-1:0] quotient,
   input logic [Y_W-1:0] remainder,
   input logic           div_zero,
   input logic           busy,
   input logic           done
);
   localparam int MX     = (A_W > B_W) ? A_W : B_W;
   localparam int WORK_W = ((MX > Y_W) ? MX : Y_W) + 1;
   localparam int RUN_W  = $clog2(WORK_W + 2) + 1;

   logic [RUN_W-1:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1'b1;
      else           busy_run <= '0;
   end

   // R5
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_run == RUN_W'(WORK_W + 1)));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R5
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7
   zero_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_zero) |-> (quotient == '1));

   // R10
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

endmodule

bind div_dual_round div_dual_round_chk #(.A_W(A_W), .B_W(B_W), .Y_W(Y_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .quotient(quotient),
   .remainder(remainder), .div_zero(div_zero), .busy(busy), .done(done)
);

// File: tb/div_dual_round_bench.sv
`timescale 1ns/1ps
module div_dual_round_bench;
   localparam int A_W = 16;
   localparam int B_W = 12;
   localparam int Y_W = 16;
   localparam int WORK_W = 17;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic           floor_mode = 1'b0;
   logic [A_W-1:0] dvd_in = '0;
   logic           dvd_signed = 1'b0;
   logic [B_W-1:0] dsr_in = '0;
   logic           dsr_signed = 1'b0;
   logic [Y_W-1:0] quotient, remainder;
   logic           div_zero, busy, done;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   div_dual_round #(.A_W(A_W), .B_W(B_W), .Y_W(Y_W)) u_div_dual_round (
      .clk(clk), .rst_n(rst_n), .start(start), .floor_mode(floor_mode),
      .dvd_in(dvd_in), .dvd_signed(dvd_signed), .dsr_in(dsr_in),
      .dsr_signed(dsr_signed), .quotient(quotient), .remainder(remainder),
      .div_zero(div_zero), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural reference using wide integers
   task automatic ref_div(input logic [A_W-1:0] a, input bit asg,
                          input logic [B_W-1:0] b, input bit bsg, input bit flr,
                          output longint q, output longint r, output bit dz);
      longint av, bv;
      av = asg ? longint'($signed(a)) : longint'(a);
      bv = bsg ? longint'($signed(b)) : longint'(b);
      dz = (bv == 0);
      if (dz) begin
         q = -1;
         r = av;
      end else begin
         q = av / bv;
         r = av % bv;
         if (flr && r != 0 && ((r < 0) != (bv < 0))) begin
            q = q - 1;
            r = r + bv;
         end
      end
   endtask

   task automatic run_op(input logic [A_W-1:0] a, input bit asg,
                         input logic [B_W-1:0] b, input bit bsg, input bit flr,
                         input bit poke, input string req);
      longint q, r;
      bit dz;
      logic [Y_W-1:0] eq, er;
      ref_div(a, asg, b, bsg, flr, q, r, dz);
      eq = q[Y_W-1:0];
      er = r[Y_W-1:0];
      @(negedge clk);
      dvd_in = a; dvd_signed = asg; dsr_in = b; dsr_signed = bsg;
      floor_mode = flr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int cyc = 0; cyc <= WORK_W; cyc++) begin
         // R5 busy high, done low while working
         chk(busy === 1'b1 && done === 1'b0, "R5 busy window", {busy, done}, 2'b10);
         if (poke && cyc == 4) begin
            dvd_in = ~a; dsr_in = b + 1'b1; floor_mode = ~flr; start = 1'b1;
         end else if (poke && cyc == 5) begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      chk(done === 1'b1 && busy === 1'b0, "R5 done pulse", {done, busy}, 2'b10);
      chk(quotient === eq, {req, " quotient"}, quotient, eq);
      chk(remainder === er, {req, " remainder"}, remainder, er);
      chk(div_zero === dz, "R7 div_zero flag", div_zero, dz);
      @(negedge clk);
      chk(done === 1'b0, "R5 single cycle done", done, 0);
      // R10 results held
      chk(quotient === eq && remainder === er, "R10 hold", quotient, eq);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(busy === 0 && done === 0 && div_zero === 0 && quotient === 0 && remainder === 0,
          "R9 in reset", {busy, done, div_zero}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 0 && done === 0 && quotient === 0 && remainder === 0,
          "R9 after reset", {busy, done}, 0);

      // R2 truncating table cases
      run_op(-16'sd10, 1, 12'd3, 1, 0, 0, "R2 -10/3");
      run_op(16'd10, 1, -12'sd3, 1, 0, 0, "R2 10/-3");
      // R3 flooring table cases
      run_op(-16'sd10, 1, 12'd3, 1, 1, 0, "R3 -10/3");
      run_op(16'd10, 1, -12'sd3, 1, 1, 0, "R3 10/-3");
      // R4 same sign and exact
      run_op(-16'sd10, 1, -12'sd3, 1, 1, 0, "R4 -10/-3 floor");
      run_op(-16'sd10, 1, -12'sd3, 1, 0, 0, "R4 -10/-3 trunc");
      run_op(16'd10, 1, 12'd3, 1, 1, 0, "R4 10/3 floor");
      run_op(-16'sd12, 1, 12'd3, 1, 1, 0, "R4 exact -12/3");
      // R1 extension by flag
      run_op(16'hFFF6, 0, 12'd3, 1, 0, 0, "R1 unsigned dividend");
      run_op(16'd100, 1, 12'hFFD, 0, 1, 0, "R1 unsigned divisor");
      run_op(16'hFFFF, 0, 12'hFFF, 1, 1, 0, "R1 mixed flags");
      // R8 most negative by -1
      run_op(16'h8000, 1, 12'hFFF, 1, 0, 0, "R8 min/-1 trunc");
      run_op(16'h8000, 1, 12'hFFF, 1, 1, 0, "R8 min/-1 floor");
      // R7 zero divisor
      run_op(-16'sd77, 1, 12'd0, 1, 1, 0, "R7 zero divisor signed");
      run_op(16'hABCD, 0, 12'd0, 0, 0, 0, "R7 zero divisor unsigned");
      // R6 start during busy ignored
      run_op(16'd1234, 1, 12'd7, 1, 1, 1, "R6 ignore start");
      // random sweep, both modes
      for (int i = 0; i < 60; i++) begin
         logic [A_W-1:0] ra;
         logic [B_W-1:0] rb;
         ra = A_W'($urandom);
         rb = B_W'($urandom);
         if (i % 7 == 0) rb = B_W'($urandom_range(1, 5));
         run_op(ra, bit'(i[0]), rb, bit'(i[1]), bit'(i[2]), 0,
                i[2] ? "R3 random floor" : "R2 random trunc");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule